// File: doc/BRIEF.md
# Reloading Modulus Down-Counter Timer

This block is a periodic event source. A down-counter, as wide as the register bus (8 bits by default), steps once per tick. The ticks come from a prescaler whose divide ratio software picks. When the counter reaches zero it reloads from a modulus register and raises a sticky underflow flag. When interrupts are enabled, the flag drives a level interrupt request. Software can also copy the modulus into the counter directly with a preset command, so the first period after a start has a known length.

Software reaches the block through a simple byte-wide register bus with an address, write data, a write strobe, a read strobe and registered read data. There are two registers: the modulus register and the control/status register. Read data appears on `bus_rdata` in the cycle after the read strobe. Reads have no side effects. The counter value itself cannot be read by software.

Top module: `modcnt_timer`

## Requirements
- R1: After reset the control/status register reads 0x00, `irq` is low and the counter receives no ticks.
- R2: The control/status register holds interrupt enable at bit 7, the underflow flag at bit 6 and rate select at bits 2:0. Bits 5, 4 and 3 always read 0, whatever was written to them.
- R3: The modulus register (address 0) reads back the last value written to it. The control/status register is at address 1.
- R4: Rate select k (1..7) gives one tick every 2^(k-1) clock cycles. The prescaler restarts from zero each time the timer leaves rate 0. With the counter preset to M, the first underflow is registered M·2^(k-1) cycles after the clock edge that writes the nonzero rate.
- R5: On an underflow the counter loads the current modulus value, so each later period lasts modulus ticks. A new modulus value takes effect only at the next underflow or preset.
- R6: An underflow happens on a tick that finds the counter at 1 (or at 0), and it sets the flag. A modulus of 0 or 1 gives an underflow on every tick.
- R7: A control write with bit 6 = 1 clears the flag. A control write with bit 6 = 0 leaves the flag unchanged.
- R8: If a flag-clear write and an underflow fall in the same cycle, the flag ends up set.
- R9: A control write with bit 3 = 1 loads the counter from the modulus register.
- R10: `irq` is high exactly when both the interrupt enable and the flag are 1. With the enable at 0, the flag still sets and can be read.
- R11: Rate select 0 stops the timer. No tick occurs, so the flag never sets, however long the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (0 = modulus, 1 = control/status) |
| bus_wdata | input | CNT_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench times each period to the exact cycle for several rates and modulus values, so a prescaler off by one phase or a counter that reloads at the wrong value shifts the interrupt edge and gets caught. It changes the modulus between a preset and the start of counting. A design that reloads from the live modulus too early, or whose preset has no effect, then gives a wrong first or second period. It places a flag-clear write on the exact edge of an underflow, where a design that gives the clear priority drops the interrupt. It also uses moduli 0 and 1, where a design that counts through zero would go silent for 256 ticks. Long stopped waits and masked-enable runs show whether a tick leaks through rate 0 or whether the flag and the request are coupled wrongly.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

   // rate select field width and the prescaler it implies
   localparam int SEL_W = 3;
   localparam int NRATE = 1 << SEL_W;
   localparam int PRE_W = NRATE - 2;

   // control/status bit positions (software visible)
   localparam int BIT_IE     = 7;
   localparam int BIT_FLAG   = 6;
   localparam int BIT_PRESET = 3;
   localparam int CTL_W      = 8;

   typedef logic [SEL_W-1:0] rate_sel_t;

   typedef struct packed {
      logic      ie;
      rate_sel_t sel;
   } ctl_t;

   function automatic logic [CTL_W-1:0] ctl_view(input ctl_t c, input logic flag);
      logic [CTL_W-1:0] v;
      v                = '0;
      v[BIT_IE]        = c.ie;
      v[BIT_FLAG]      = flag;
      v[SEL_W-1:0]     = c.sel;
      return v;
   endfunction

endpackage

// File: rtl/modcnt_prescaler.sv
module modcnt_prescaler
   import modcnt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rate_sel_t sel,
   output logic      tick
);

   logic [PRE_W-1:0] pcnt_q;
   logic [NRATE-1:0] hit;

   // prescaler is held at zero while stopped so the first period is exact
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (sel == '0)
         pcnt_q <= '0;
      else
         pcnt_q <= pcnt_q + 1'b1;
   end

   assign hit[0] = 1'b0;

   // one match term per divide ratio: rate k ticks every 2^(k-1) cycles
   for (genvar k = 1; k < NRATE; k++) begin : g_rate
      if (k == 1) begin : g_div1
         assign hit[k] = 1'b1;
      end else begin : g_divn
         assign hit[k] = &pcnt_q[k-2:0];
      end
   end

   assign tick = hit[sel];

endmodule

// File: rtl/modcnt_core.sv
module modcnt_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             preset,
   input  logic             clr,
   input  logic [CNT_W-1:0] modulus,
   output logic [CNT_W-1:0] cnt,
   output logic             flag,
   output logic             uf
);

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;

   // underflow: a tick that finds the counter at 1 or 0
   assign uf = tick && !preset && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (preset)
         cnt_q <= modulus;
      else if (uf)
         cnt_q <= modulus;
      else if (tick)
         cnt_q <= cnt_q - 1'b1;
   end

   // setting outranks a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (uf)
         flag_q <= 1'b1;
      else if (clr)
         flag_q <= 1'b0;
   end

   assign cnt  = cnt_q;
   assign flag = flag_q;

endmodule

// File: rtl/modcnt_regs.sv
module modcnt_regs
   import modcnt_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 1,
   parameter int MOD_ADDR = 0,
   parameter int CTL_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              flag,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [CNT_W-1:0]  mod_q,
   output ctl_t              ctl_q,
   output logic              preset_p,
   output logic              clr_p
);

   logic wr_mod, wr_ctl, sel_mod, sel_ctl;

   assign sel_mod  = (bus_addr == ADDR_W'(MOD_ADDR));
   assign sel_ctl  = (bus_addr == ADDR_W'(CTL_ADDR));
   assign wr_mod   = bus_wr && sel_mod;
   assign wr_ctl   = bus_wr && sel_ctl;
   assign preset_p = wr_ctl && bus_wdata[BIT_PRESET];
   assign clr_p    = wr_ctl && bus_wdata[BIT_FLAG];

   // modulus has no reset value
   always_ff @(posedge clk) begin
      if (wr_mod)
         mod_q <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q.ie  <= bus_wdata[BIT_IE];
         ctl_q.sel <= bus_wdata[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd) begin
         if (sel_mod)
            bus_rdata <= mod_q;
         else if (sel_ctl)
            bus_rdata <= CNT_W'(ctl_view(ctl_q, flag));
         else
            bus_rdata <= '0;
      end
   end

endmodule

// File: rtl/modcnt_timer.sv
module modcnt_timer
   import modcnt_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 1,
   parameter int MOD_ADDR = 0,
   parameter int CTL_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);

   initial begin
      assert (CNT_W >= CTL_W) else $error("CNT_W must hold the control byte");
      assert (MOD_ADDR != CTL_ADDR) else $error("register addresses collide");
      assert (CTL_ADDR < (1 << ADDR_W) && MOD_ADDR < (1 << ADDR_W))
         else $error("register address out of range");
   end

   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] cnt_q;
   ctl_t             ctl_q;
   logic             preset_p, clr_p, tick, uf, flag_q;

   modcnt_regs #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MOD_ADDR(MOD_ADDR), .CTL_ADDR(CTL_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .flag      (flag_q),
      .bus_rdata (bus_rdata),
      .mod_q     (mod_q),
      .ctl_q     (ctl_q),
      .preset_p  (preset_p),
      .clr_p     (clr_p)
   );

   modcnt_prescaler u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (ctl_q.sel),
      .tick  (tick)
   );

   modcnt_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .preset  (preset_p),
      .clr     (clr_p),
      .modulus (mod_q),
      .cnt     (cnt_q),
      .flag    (flag_q),
      .uf      (uf)
   );

   assign irq = ctl_q.ie && flag_q;

endmodule

// File: rtl/modcnt_timer_chk.sv
module modcnt_timer_chk
   import modcnt_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 1,
   parameter int CTL_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [CNT_W-1:0]  bus_rdata,
   input logic              irq,
   input logic              tick,
   input logic              uf,
   input logic              flag,
   input logic              ie,
   input rate_sel_t         sel,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  mod_q
);

   logic ctl_wr;
   assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));

   a_r11_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !tick);

   a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !uf && !(ctl_wr && bus_wdata[BIT_PRESET])) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> (cnt == $past(mod_q)));

   a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[BIT_PRESET]) |=> (cnt == $past(mod_q)));

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> flag);

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[BIT_FLAG] && !uf) |=> !flag);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(ctl_wr && bus_wdata[BIT_FLAG])) |=> flag);

   a_r10_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie && flag));

   a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(CTL_ADDR)) |=> (bus_rdata[5:3] == 3'b000));

endmodule

bind modcnt_timer modcnt_timer_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .tick      (tick),
   .uf        (uf),
   .flag      (flag_q),
   .ie        (ctl_q.ie),
   .sel       (ctl_q.sel),
   .cnt       (cnt_q),
   .mod_q     (mod_q)
);

// File: tb/modcnt_timer_bench.sv
`timescale 1ns/1ps
module modcnt_timer_bench;

   localparam logic A_MOD = 1'b0;
   localparam logic A_CTL = 1'b1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [0:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   modcnt_timer u_modcnt_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // all bus tasks start and end just after a falling edge
   task automatic wr(input logic a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic stop_all();
      wr(A_CTL, 8'h40);
   endtask

   task automatic arm(input logic [7:0] m, input logic [2:0] s, input logic ie);
      stop_all();
      wr(A_MOD, m);
      wr(A_CTL, 8'h08);
      wr(A_CTL, {ie, 1'b1, 3'b000, s});
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 irq after reset", int'(irq), 0);
      rd(A_CTL, d);
      chk("R1 control after reset", int'(d), 8'h00);
      repeat (100) @(negedge clk);
      rd(A_CTL, d);
      chk("R1 unclocked, no flag", int'(d), 8'h00);
   endtask

   task automatic t_layout();
      logic [7:0] d;
      wr(A_CTL, 8'hBF);
      rd(A_CTL, d);
      chk("R2 bits 5..3 read zero", int'(d), 8'h87);
      stop_all();
      rd(A_CTL, d);
      chk("R2 stop readback", int'(d), 8'h00);
      wr(A_MOD, 8'hA5);
      rd(A_MOD, d);
      chk("R3 modulus readback A5", int'(d), 8'hA5);
      wr(A_MOD, 8'h5A);
      rd(A_MOD, d);
      chk("R3 modulus readback 5A", int'(d), 8'h5A);
   endtask

   // period of M*D cycles, then clear and check the reloaded period
   task automatic t_period(input int m, input logic [2:0] s);
      int d, p;
      d = 1 << (s - 1);
      p = m * d;
      arm(8'(m), s, 1'b1);
      for (int n = 1; n <= p; n++) begin
         @(negedge clk);
         if (n == p - 1) chk($sformatf("R4 low before first underflow m=%0d s=%0d", m, s), int'(irq), 0);
         if (n == p)     chk($sformatf("R4 R6 first underflow m=%0d s=%0d", m, s), int'(irq), 1);
      end
      wr(A_CTL, {1'b1, 1'b1, 3'b000, s});
      chk("R7 clear drops irq", int'(irq), 0);
      for (int n = p + 2; n <= 2 * p; n++) begin
         @(negedge clk);
         if (n == 2 * p - 1) chk($sformatf("R5 low before reload period end m=%0d", m), int'(irq), 0);
         if (n == 2 * p)     chk($sformatf("R5 second period m=%0d s=%0d", m, s), int'(irq), 1);
      end
      stop_all();
   endtask

   task automatic t_priority();
      logic [7:0] d;
      arm(8'd3, 3'd1, 1'b1);
      @(negedge clk);
      @(negedge clk);
      wr(A_CTL, 8'hC1);
      chk("R8 set wins over clear", int'(irq), 1);
      wr(A_CTL, 8'h81);
      chk("R7 writing zero keeps flag", int'(irq), 1);
      rd(A_CTL, d);
      chk("R2 R7 status readback", int'(d), 8'hC1);
      stop_all();
   endtask

   task automatic t_fast(input logic [7:0] m);
      arm(m, 3'd1, 1'b1);
      @(negedge clk);
      chk($sformatf("R6 modulus %0d underflows first tick", m), int'(irq), 1);
      wr(A_CTL, 8'hC1);
      chk($sformatf("R6 modulus %0d underflows every tick", m), int'(irq), 1);
      stop_all();
   endtask

   task automatic t_preset();
      logic [7:0] d;
      stop_all();
      wr(A_MOD, 8'd10);
      wr(A_CTL, 8'h08);
      wr(A_MOD, 8'd3);
      wr(A_CTL, 8'hC1);
      for (int n = 1; n <= 10; n++) begin
         @(negedge clk);
         if (n == 9)  chk("R9 preset value still counting", int'(irq), 0);
         if (n == 10) chk("R9 preset period", int'(irq), 1);
      end
      wr(A_CTL, 8'hC1);
      @(negedge clk);
      chk("R5 new modulus not yet expired", int'(irq), 0);
      @(negedge clk);
      chk("R5 new modulus used at reload", int'(irq), 1);
      rd(A_MOD, d);
      chk("R3 modulus holds last write", int'(d), 3);
      stop_all();
   endtask

   task automatic t_gate();
      logic [7:0] d;
      arm(8'd2, 3'd1, 1'b0);
      repeat (5) @(negedge clk);
      chk("R10 masked flag keeps irq low", int'(irq), 0);
      rd(A_CTL, d);
      chk("R10 flag visible while masked", int'(d), 8'h41);
      wr(A_CTL, 8'h81);
      chk("R10 enabling raises irq", int'(irq), 1);
      stop_all();
      chk("R10 clear lowers irq", int'(irq), 0);
   endtask

   task automatic t_stop();
      logic [7:0] d;
      stop_all();
      wr(A_MOD, 8'd1);
      wr(A_CTL, 8'h08);
      wr(A_CTL, 8'h80);
      repeat (300) @(negedge clk);
      chk("R11 stopped timer raises nothing", int'(irq), 0);
      rd(A_CTL, d);
      chk("R11 stopped flag clear", int'(d), 8'h80);
      stop_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_period(5, 3'd1);
      t_period(3, 3'd3);
      t_period(2, 3'd7);
      t_period(200, 3'd2);
      t_period(4, 3'd5);
      t_priority();
      t_fast(8'd1);
      t_fast(8'd0);
      t_preset();
      t_gate();
      t_stop();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule